// File: doc/BRIEF.md
# DMA Bus Request Arbiter

This block sits between a transmit DMA engine, a receive DMA engine and the master side of a shared host bus. Each cycle it looks at how much room the transmit FIFO has and how full the receive FIFO is. From these levels it forms two kinds of request for each direction. An efficient request waits until a long burst is worth doing. An urgent request ignores the burst threshold and is raised when a transmit underrun or a receive overrun is close.

The four requests go through a fixed-priority picker. When the bus is idle and no burst is running, the winner gets a registered, one-hot grant. That grant stays in place until the bus interface reports that the burst is done. The block also tells the granted engine whether it may use the cache-line write command type (receive) or the cache-line read command type (transmit). Two disable bits can suppress each command type. When both bits are zero, both command types are allowed.

All thresholds are programmable inputs sized to the FIFO level width. The FIFO depth is a parameter.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released with no requests present, all four grant outputs and both command flags are 0.
- R2: The transmit efficient request is present exactly when `tx_want` is 1 and `tx_free >= tx_burst_thr`.
- R3: The transmit urgent request is present exactly when `tx_frame_active` is 1 and FIFO occupancy (`DEPTH - tx_free`) is below `tx_urg_thr`, whatever the burst threshold is.
- R4: The receive efficient request is present exactly when `rx_fill` is non-zero and `rx_fill >= rx_burst_thr`.
- R5: The receive urgent request is present exactly when receive free space (`DEPTH - rx_fill`) is below `rx_urg_thr`.
- R6: At a rising edge where no grant is held, `bus_idle` is 1 and at least one request is present, the block grants the highest-priority request. The order from highest to lowest is receive urgent, transmit urgent, receive efficient, transmit efficient. The grant is visible after that edge.
- R7: At most one of `gnt_rx_urg`, `gnt_tx_urg`, `gnt_rx`, `gnt_tx` is 1 in any cycle.
- R8: A grant keeps its value on every edge where `burst_done` is 0, whatever the requests and `bus_idle` do.
- R9: The edge that samples `burst_done` = 1 while a grant is held clears that grant. No grant is issued at that edge, and the earliest next grant comes at the following edge.
- R10: No grant is issued at an edge where `bus_idle` is 0.
- R11: When a grant is issued, `use_mwi` becomes `!mwi_disable` for a receive grant (efficient or urgent) and 0 otherwise. `use_mrl` becomes `!mrl_disable` for a transmit grant and 0 otherwise. Both flags hold with the grant and clear with it.
- R12: `burst_done` has no effect while no grant is held. In that state a grant is issued under the R6 rule even if `burst_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_free | input | LVL_W | Free entries in the transmit FIFO (0..DEPTH) |
| tx_want | input | 1 | Transmit engine has data to fetch |
| tx_frame_active | input | 1 | A transmit frame is being sent |
| tx_burst_thr | input | LVL_W | Minimum free space for an efficient transmit request |
| tx_urg_thr | input | LVL_W | Occupancy below which transmit is urgent |
| rx_fill | input | LVL_W | Used entries in the receive FIFO (0..DEPTH) |
| rx_burst_thr | input | LVL_W | Minimum fill for an efficient receive request |
| rx_urg_thr | input | LVL_W | Free space below which receive is urgent |
| mwi_disable | input | 1 | Suppress the cache-line write command type |
| mrl_disable | input | 1 | Suppress the cache-line read command type |
| bus_idle | input | 1 | Bus interface can start a new burst |
| burst_done | input | 1 | Bus interface finished the granted burst |
| gnt_tx | output | 1 | Grant to the transmit efficient request |
| gnt_rx | output | 1 | Grant to the receive efficient request |
| gnt_tx_urg | output | 1 | Grant to the transmit urgent request |
| gnt_rx_urg | output | 1 | Grant to the receive urgent request |
| use_mwi | output | 1 | Granted receive burst may use cache-line write |
| use_mrl | output | 1 | Granted transmit burst may use cache-line read |

## Verification
Several behaviours are checked by assertions on every cycle: only one grant at a time, a grant held steady until the done handshake, the idle gap after done, no start while the bus is busy, and each new grant being the highest request of the previous cycle. The command flags are checked against the grant they belong to. The exact request conditions at threshold boundaries, the command-flag values under the disable bits, and done being ignored while idle are only shown by the bench. It drives directed edge cases and random level and threshold mixes, and compares the ports with its own model.

// File: rtl/dba_pkg.sv
package dba_pkg;
  localparam int NREQ = 4;
  // request slot index; a larger index has higher priority
  typedef enum logic [1:0] {
    SRC_TX_NORM = 2'd0,
    SRC_RX_NORM = 2'd1,
    SRC_TX_URG  = 2'd2,
    SRC_RX_URG  = 2'd3
  } src_e;
  typedef enum logic {ARB_IDLE = 1'b0, ARB_BUSY = 1'b1} arb_state_e;
endpackage

// File: rtl/dba_req_gen.sv
module dba_req_gen #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] tx_free,
  input  logic             tx_want,
  input  logic             tx_frame_active,
  input  logic [LVL_W-1:0] tx_burst_thr,
  input  logic [LVL_W-1:0] tx_urg_thr,
  input  logic [LVL_W-1:0] rx_fill,
  input  logic [LVL_W-1:0] rx_burst_thr,
  input  logic [LVL_W-1:0] rx_urg_thr,
  output logic [dba_pkg::NREQ-1:0] req
);
  import dba_pkg::*;
  localparam int W = LVL_W + 1;

  // entries on the other side of a level: occupancy from free, free from fill
  function automatic logic [W-1:0] complement_of(input logic [LVL_W-1:0] lvl);
    return W'(DEPTH) - {1'b0, lvl};
  endfunction

  function automatic logic below(input logic [W-1:0] amount, input logic [LVL_W-1:0] thr);
    return amount < {1'b0, thr};
  endfunction

  logic [W-1:0] tx_used, rx_room;
  logic tx_eff, tx_urg, rx_eff, rx_urg;

  assign tx_used = complement_of(tx_free);
  assign rx_room = complement_of(rx_fill);
  assign tx_eff  = tx_want && (tx_free >= tx_burst_thr);            // R2
  assign tx_urg  = tx_frame_active && below(tx_used, tx_urg_thr);   // R3
  assign rx_eff  = (rx_fill != '0) && (rx_fill >= rx_burst_thr);    // R4
  assign rx_urg  = below(rx_room, rx_urg_thr);                      // R5

  always_comb begin
    req = '0;
    req[SRC_TX_NORM] = tx_eff;
    req[SRC_RX_NORM] = rx_eff;
    req[SRC_TX_URG]  = tx_urg;
    req[SRC_RX_URG]  = rx_urg;
  end
endmodule

// File: rtl/dba_prio_pick.sv
module dba_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_slot
      if (i == N - 1) begin : g_top
        assign pick[i] = req[i];
      end else begin : g_low
        assign pick[i] = req[i] && !(|req[N-1:i+1]);
      end
    end
  endgenerate

  always_comb begin
    AST_PICK_ONE: assert (req == '0 || $countones(pick) == 1); // R6
  end
endmodule

// File: rtl/dba_grant_fsm.sv
module dba_grant_fsm #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_idle,
  input  logic         burst_done,
  input  logic         mwi_disable,
  input  logic         mrl_disable,
  input  logic [N-1:0] req,
  input  logic [N-1:0] pick,
  output logic [N-1:0] gnt,
  output logic         use_mwi,
  output logic         use_mrl
);
  import dba_pkg::*;

  arb_state_e state;
  logic grant_start, grant_end, pick_is_rx, pick_is_tx;

  // named events for the assertions
  assign grant_start = (state == ARB_IDLE) && bus_idle && (|req);
  assign grant_end   = (state == ARB_BUSY) && burst_done;
  assign pick_is_rx  = pick[SRC_RX_NORM] || pick[SRC_RX_URG];
  assign pick_is_tx  = pick[SRC_TX_NORM] || pick[SRC_TX_URG];

  function automatic logic [N-1:0] above_mask(input logic [N-1:0] onehot);
    return ~((onehot << 1) - N'(1));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ARB_IDLE;
      gnt     <= '0;
      use_mwi <= 1'b0;
      use_mrl <= 1'b0;
    end else if (grant_end) begin
      state   <= ARB_IDLE;
      gnt     <= '0;
      use_mwi <= 1'b0;
      use_mrl <= 1'b0;
    end else if (grant_start) begin
      state   <= ARB_BUSY;
      gnt     <= pick;
      use_mwi <= pick_is_rx && !mwi_disable;
      use_mrl <= pick_is_tx && !mrl_disable;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R7
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !burst_done) |=> $stable(gnt)); // R8
  AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && burst_done) |=> (gnt == '0)); // R9
  AST_NEED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt == '0) && !bus_idle) |=> (gnt == '0)); // R10
  AST_PRIO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !$past(|gnt)) |->
      ((($past(req) & above_mask(gnt)) == '0) && (($past(req) & gnt) != '0))); // R6
  AST_MWI_RX: assert property (@(posedge clk) disable iff (!rst_n)
    use_mwi |-> (gnt[SRC_RX_NORM] || gnt[SRC_RX_URG])); // R11
  AST_MRL_TX: assert property (@(posedge clk) disable iff (!rst_n)
    use_mrl |-> (gnt[SRC_TX_NORM] || gnt[SRC_TX_URG])); // R11
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int DEPTH = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_free,
  input  logic             tx_want,
  input  logic             tx_frame_active,
  input  logic [LVL_W-1:0] tx_burst_thr,
  input  logic [LVL_W-1:0] tx_urg_thr,
  input  logic [LVL_W-1:0] rx_fill,
  input  logic [LVL_W-1:0] rx_burst_thr,
  input  logic [LVL_W-1:0] rx_urg_thr,
  input  logic             mwi_disable,
  input  logic             mrl_disable,
  input  logic             bus_idle,
  input  logic             burst_done,
  output logic             gnt_tx,
  output logic             gnt_rx,
  output logic             gnt_tx_urg,
  output logic             gnt_rx_urg,
  output logic             use_mwi,
  output logic             use_mrl
);
  import dba_pkg::*;

  logic [NREQ-1:0] req, pick, gnt;

  dba_req_gen #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_req (
    .tx_free(tx_free), .tx_want(tx_want), .tx_frame_active(tx_frame_active),
    .tx_burst_thr(tx_burst_thr), .tx_urg_thr(tx_urg_thr),
    .rx_fill(rx_fill), .rx_burst_thr(rx_burst_thr), .rx_urg_thr(rx_urg_thr),
    .req(req)
  );

  dba_prio_pick #(.N(NREQ)) u_pick (.req(req), .pick(pick));

  dba_grant_fsm #(.N(NREQ)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .burst_done(burst_done),
    .mwi_disable(mwi_disable), .mrl_disable(mrl_disable),
    .req(req), .pick(pick), .gnt(gnt), .use_mwi(use_mwi), .use_mrl(use_mrl)
  );

  assign gnt_tx     = gnt[SRC_TX_NORM];
  assign gnt_rx     = gnt[SRC_RX_NORM];
  assign gnt_tx_urg = gnt[SRC_TX_URG];
  assign gnt_rx_urg = gnt[SRC_RX_URG];

  AST_TX_BURST_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_tx && !$past(gnt_tx)) |-> $past(tx_free >= tx_burst_thr)); // R2
endmodule

// File: tb/sim_dma_bus_arbiter.sv
module sim_dma_bus_arbiter;
  localparam int DEPTH = 64;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LVL_W-1:0] tx_free, tx_burst_thr, tx_urg_thr, rx_fill, rx_burst_thr, rx_urg_thr;
  logic tx_want, tx_frame_active, mwi_disable, mrl_disable, bus_idle, burst_done;
  logic gnt_tx, gnt_rx, gnt_tx_urg, gnt_rx_urg, use_mwi, use_mrl;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  dma_bus_arbiter #(.DEPTH(DEPTH)) u0 (.*);

  // bench model: request bits {rx_urg, tx_urg, rx, tx}
  function automatic logic [3:0] want_vec();
    logic [3:0] r;
    r[0] = tx_want && (int'(tx_free) >= int'(tx_burst_thr));
    r[1] = (rx_fill != 0) && (int'(rx_fill) >= int'(rx_burst_thr));
    r[2] = tx_frame_active && (int'(tx_free) + int'(tx_urg_thr) > DEPTH);
    r[3] = (int'(rx_fill) + int'(rx_urg_thr) > DEPTH);
    return r;
  endfunction

  function automatic logic [3:0] winner(input logic [3:0] r);
    if (r[3]) return 4'b1000;
    if (r[2]) return 4'b0100;
    if (r[1]) return 4'b0010;
    if (r[0]) return 4'b0001;
    return 4'b0000;
  endfunction

  logic [3:0] m_gnt;
  logic m_mwi, m_mrl;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gnt <= 0; m_mwi <= 0; m_mrl <= 0;
    end else if (m_gnt != 0) begin
      if (burst_done) begin m_gnt <= 0; m_mwi <= 0; m_mrl <= 0; end
    end else if (bus_idle && want_vec() != 0) begin
      m_gnt <= winner(want_vec());
      m_mwi <= (winner(want_vec()) & 4'b1010) != 0 && !mwi_disable;
      m_mrl <= (winner(want_vec()) & 4'b0101) != 0 && !mrl_disable;
    end
  end

  task automatic check_out(input string tag);
    logic [5:0] act, exp;
    act = {gnt_rx_urg, gnt_tx_urg, gnt_rx, gnt_tx, use_mwi, use_mrl};
    exp = {m_gnt, m_mwi, m_mrl};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s grant/flags actual=%b expected=%b", tag, act, exp);
    end
    checks++;
    if ($countones(act[5:2]) > 1) begin
      failures++;
      $display("FAIL R7 grants actual=%b expected=onehot0", act[5:2]);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk); @(negedge clk);
    check_out(tag);
  endtask

  task automatic quiet();
    tx_free = DEPTH; tx_want = 0; tx_frame_active = 0;
    tx_burst_thr = 32; tx_urg_thr = 8; rx_fill = 0; rx_burst_thr = 16; rx_urg_thr = 8;
    mwi_disable = 0; mrl_disable = 0; bus_idle = 1; burst_done = 0;
  endtask

  task automatic finish_burst(input string tag);
    burst_done = 1; step(tag); burst_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    quiet();
    repeat (3) @(negedge clk);
    check_out("R1");
    rst_n = 1;
    step("R1");
    // R2 threshold edge: equal passes, one below does not
    tx_want = 1; tx_free = 31; step("R2");
    tx_free = 32; step("R2");
    finish_burst("R9"); tx_want = 0; step("R9");
    // R3 urgent ignores burst threshold; occupancy 7 < 8, 8 not
    tx_frame_active = 1; tx_free = DEPTH - 8; step("R3");
    tx_free = DEPTH - 7; tx_burst_thr = DEPTH; step("R3");
    finish_burst("R3"); tx_frame_active = 0; step("R9");
    // R4: empty FIFO with zero threshold makes no request
    rx_burst_thr = 0; rx_fill = 0; step("R4");
    rx_fill = 1; mwi_disable = 1; step("R4");
    finish_burst("R11"); rx_fill = 0;
    // R5 boundary: free 8 not urgent, free 7 urgent
    rx_fill = DEPTH - 8; rx_burst_thr = DEPTH; step("R5");
    rx_fill = DEPTH - 7; mwi_disable = 0; step("R5");
    finish_burst("R5");
    // R6 all four at once, then drain by priority
    rx_burst_thr = 16; tx_want = 1; tx_free = DEPTH - 2; tx_frame_active = 1;
    tx_burst_thr = 8; step("R6");
    finish_burst("R6"); step("R6");
    rx_fill = 20; finish_burst("R6"); step("R6");
    // R8: grant held while higher request rises and bus_idle drops
    tx_frame_active = 0; rx_fill = 0; finish_burst("R8"); step("R8");
    rx_fill = DEPTH; bus_idle = 0; step("R8"); step("R8");
    finish_burst("R9");
    // R10: no grant without bus_idle
    step("R10"); step("R10");
    // R12: done while idle ignored, grant still issued
    bus_idle = 1; burst_done = 1; step("R12"); burst_done = 0;
    finish_burst("R9"); rx_fill = 0; tx_want = 0; step("R9");
    // R11 transmit with read-line disabled and enabled
    tx_want = 1; mrl_disable = 1; step("R11");
    finish_burst("R11"); mrl_disable = 0; step("R11");
    finish_burst("R11");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (i % 50 == 0) begin
        tx_burst_thr = LVL_W'($urandom_range(0, DEPTH));
        tx_urg_thr   = LVL_W'($urandom_range(0, DEPTH / 2));
        rx_burst_thr = LVL_W'($urandom_range(0, DEPTH));
        rx_urg_thr   = LVL_W'($urandom_range(0, DEPTH / 2));
      end
      tx_free = LVL_W'($urandom_range(0, DEPTH));
      rx_fill = LVL_W'($urandom_range(0, DEPTH));
      tx_want = 1'($urandom_range(0, 1));
      tx_frame_active = 1'($urandom_range(0, 1));
      mwi_disable = ($urandom_range(0, 3) == 0);
      mrl_disable = ($urandom_range(0, 3) == 0);
      bus_idle = ($urandom_range(0, 9) < 7);
      burst_done = ($urandom_range(0, 3) == 0);
      step("R6 R8 R9 random");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule